// File: doc/BRIEF.md
# Pin-Selected Control Register Bank

This block is the digital control store of a rate-selectable receive front end. It holds twelve writable control registers (addresses 0 to 11) and two read-only status registers (addresses 14 and 15), and it turns their contents into decoded control fields for the analog path. A serial slave outside the block reaches it through a plain parallel write and read port.

Two external selection pins choose one of four filter-bandwidth registers and, together with it, one of four loss-of-signal level registers. Each of these eight registers has a flag in bit 7. When the flag is set, the stored code drives the output. When the flag is clear, a built-in default code for that pin pair is used instead. The resolved bandwidth and level codes can be read back through the two status registers.

The selection pins are synchronised before use. An unconnected high pin reads as 1 and an unconnected low pin reads as 0. To model this, the synchroniser resets to that state, so out of reset the bank uses the fourth register pair.

Top module: `ratesel_ctrl_bank`

## Requirements
- R1: After reset, every writable register holds 0, all decoded control outputs are 0, `bw_code` is 4'b0000 and `los_code` is the default level of the pin pair 10.
- R2: Register 0 drives `bus_lock` from bit 0, `ofs_cancel_off` from bit 1, `los_range_hi` from bit 2 and `out_disable` from bit 3. Its bits 7:4 always read 0.
- R3: Register 1 stores all 8 bits, reads them back and drives `thresh_adj`. The code 128 stands for zero shift, 1 to 127 for a positive shift and 129 to 255 for a negative shift.
- R4: Register 2 bits 3:0 drive `preemph`, and register 3 bits 1:0 select the amplitude. On `amp_level`, 00 gives 0 (low), 01 and 10 both give 1 (middle) and 11 gives 2 (high). All other bits of these registers read 0.
- R5: `preemph_bad` is 1 exactly when the stored pre-emphasis code is outside {0000, 0001, 0011, 0100, 0101, 0111, 1100, 1101, 1111}. An out-of-set code is still stored and read back as written.
- R6: The pin pair {sel_hi, sel_lo} selects the bandwidth register: 00 selects register 4, 01 register 5, 11 register 6 and 10 register 7. These registers keep bits 7 and 3:0, and their bits 6:4 read 0. With the flag (bit 7) set, `bw_code` is bits 3:0 of the selected register. With the flag clear, `bw_code` is the default code 1111, 0101, 0010 or 0000 for pair 00, 01, 11 or 10.
- R7: The same pin pair selects the level register: 00 selects register 8, 01 register 9, 11 register 10 and 10 register 11. With the flag (bit 7) set, `los_code` is bits 6:0 of the selected register. With the flag clear, `los_code` is that pair's default-level parameter.
- R8: Reading address 14 returns {4'b0, bw_code}, reading address 15 returns {1'b0, los_code}, and reading addresses 12 and 13 returns 0. Writes to addresses 12 to 15 change nothing.
- R9: Once bit 0 of register 0 is 1, every later write is ignored until reset, and reads still return the stored data.
- R10: A register write at clock edge k shows on `bw_code` and `los_code` at edge k+1. A pin change shows after SYNC_STAGES+1 edges.
- R11: From reset until the synchroniser has filled, the pins read as sel_hi=1 and sel_lo=0, whatever is driven on them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_hi_pin | input | 1 | Upper rate-select pin (asynchronous) |
| sel_lo_pin | input | 1 | Lower rate-select pin (asynchronous) |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 8 | Read data, combinational from rd_addr |
| bw_code | output | 4 | Resolved bandwidth code |
| los_code | output | 7 | Resolved loss-of-signal level code |
| out_disable | output | 1 | Output stage disable |
| los_range_hi | output | 1 | High loss-of-signal range select |
| ofs_cancel_off | output | 1 | Offset cancellation disable |
| bus_lock | output | 1 | Write lock, sticky until reset |
| thresh_adj | output | 8 | Input threshold code |
| preemph | output | 4 | Pre-emphasis code |
| preemph_bad | output | 1 | Pre-emphasis code outside the valid set |
| amp_level | output | 2 | Decoded amplitude: 0 low, 1 middle, 2 high |

## Verification
The bench builds the block with SYNC_STAGES=2 and sets the four default-level parameters to 7'h11, 7'h22, 7'h33 and 7'h44. Because the four values differ, every pin pair resolves to a distinct level, so a wrong pair-to-register mapping or a default taken from the wrong pair shows up directly on `los_code`. With two synchroniser stages, the reset value of the synchroniser can be observed for exactly two edges after reset before the driven pins take over.

// File: rtl/rsb_pkg.sv
package rsb_pkg;

   localparam int unsigned ADR_CTRL   = 0;
   localparam int unsigned ADR_THR    = 1;
   localparam int unsigned ADR_PE     = 2;
   localparam int unsigned ADR_AMP    = 3;
   localparam int unsigned ADR_BW0    = 4;
   localparam int unsigned ADR_LOS0   = 8;
   localparam int unsigned ADR_BWSTAT = 14;
   localparam int unsigned ADR_LVSTAT = 15;

   typedef enum logic [1:0] {
      AMP_LOW  = 2'd0,
      AMP_MID  = 2'd1,
      AMP_HIGH = 2'd2
   } amp_lvl_e;

   // writable-bit mask per register index
   function automatic logic [7:0] reg_mask(input int unsigned idx);
      if (idx == ADR_CTRL || idx == ADR_PE) return 8'h0F;
      if (idx == ADR_AMP)                   return 8'h03;
      if (idx >= ADR_BW0 && idx < ADR_LOS0) return 8'h8F;
      return 8'hFF;
   endfunction

   function automatic logic pe_code_ok(input logic [3:0] c);
      case (c)
         4'b0000, 4'b0001, 4'b0011, 4'b0100, 4'b0101,
         4'b0111, 4'b1100, 4'b1101, 4'b1111: return 1'b1;
         default:                            return 1'b0;
      endcase
   endfunction

   // pin pair to bank slot: 00->0, 01->1, 11->2, 10->3
   function automatic logic [1:0] pair_slot(input logic [1:0] p);
      case (p)
         2'b00:   return 2'd0;
         2'b01:   return 2'd1;
         2'b11:   return 2'd2;
         default: return 2'd3;
      endcase
   endfunction

   function automatic logic [3:0] bw_default(input logic [1:0] slot);
      case (slot)
         2'd0:    return 4'b1111;
         2'd1:    return 4'b0101;
         2'd2:    return 4'b0010;
         default: return 4'b0000;
      endcase
   endfunction

endpackage

// File: rtl/rsb_sync.sv
module rsb_sync #(
   parameter int unsigned       W       = 2,
   parameter int unsigned       STAGES  = 2,
   parameter logic [W-1:0]      RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("rsb_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] stg_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
      end else begin
         stg_q[0] <= d_i;
         for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      end
   end

   assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/rsb_regfile.sv
module rsb_regfile
   import rsb_pkg::*;
#(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned NREG   = 12
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [ADDR_W-1:0]           wr_addr,
   input  logic [DATA_W-1:0]           wr_data,
   output logic [NREG-1:0][DATA_W-1:0] regs_o,
   output logic                        lock_o
);

   generate
      if (NREG > (1 << ADDR_W)) begin : g_bad_size
         $error("rsb_regfile: NREG exceeds address space");
      end
      if (DATA_W != 8) begin : g_bad_width
         $error("rsb_regfile: DATA_W must be 8");
      end
   endgenerate

   logic [NREG-1:0][DATA_W-1:0] regs_q;
   logic                        lock;

   assign lock = regs_q[ADR_CTRL][0];

   genvar gi;
   generate
      for (gi = 0; gi < NREG; gi++) begin : g_reg
         localparam logic [DATA_W-1:0] MASK = reg_mask(gi);
         logic hit;
         assign hit = wr_en && !lock && (wr_addr == ADDR_W'(gi));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   regs_q[gi] <= '0;
            else if (hit) regs_q[gi] <= wr_data & MASK;
         end
      end
   endgenerate

   assign regs_o = regs_q;
   assign lock_o = lock;

   p_lock_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      lock |=> lock);
   p_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
      lock |=> $stable(regs_q));

endmodule

// File: rtl/rsb_resolve.sv
module rsb_resolve
   import rsb_pkg::*;
#(
   parameter int unsigned       BW_W     = 4,
   parameter int unsigned       LV_W     = 7,
   parameter logic [LV_W-1:0]   LV_DEF00 = 7'h00,
   parameter logic [LV_W-1:0]   LV_DEF01 = 7'h0C,
   parameter logic [LV_W-1:0]   LV_DEF11 = 7'h2C,
   parameter logic [LV_W-1:0]   LV_DEF10 = 7'h2C
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [1:0]           pair_i,
   input  logic [3:0][7:0]      bw_regs_i,
   input  logic [3:0][7:0]      lv_regs_i,
   output logic [BW_W-1:0]      bw_o,
   output logic [LV_W-1:0]      lv_o
);

   generate
      if (BW_W != 4 || LV_W != 7) begin : g_bad_fields
         $error("rsb_resolve: field widths must be 4 and 7");
      end
   endgenerate

   localparam logic [3:0][LV_W-1:0] LV_DEF = {LV_DEF10, LV_DEF11, LV_DEF01, LV_DEF00};

   logic [1:0]      slot;
   logic [7:0]      bw_sel, lv_sel;
   logic [BW_W-1:0] bw_d;
   logic [LV_W-1:0] lv_d;

   always_comb begin
      slot   = pair_slot(pair_i);
      bw_sel = bw_regs_i[slot];
      lv_sel = lv_regs_i[slot];
      bw_d   = bw_sel[7] ? bw_sel[BW_W-1:0] : bw_default(slot);
      lv_d   = lv_sel[7] ? lv_sel[LV_W-1:0] : LV_DEF[slot];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bw_o <= bw_default(2'd3);
         lv_o <= LV_DEF10;
      end else begin
         bw_o <= bw_d;
         lv_o <= lv_d;
      end
   end

   p_bw_dflt_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(pair_i) == 2'b00 && !$past(bw_regs_i[0][7])) |-> bw_o == 4'b1111);
   p_lv_prog_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(pair_i) == 2'b10 && $past(lv_regs_i[3][7]))
         |-> lv_o == $past(lv_regs_i[3][6:0]));

endmodule

// File: rtl/ratesel_ctrl_bank.sv
module ratesel_ctrl_bank
   import rsb_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [6:0]  LV_DEF00    = 7'h00,
   parameter logic [6:0]  LV_DEF01    = 7'h0C,
   parameter logic [6:0]  LV_DEF11    = 7'h2C,
   parameter logic [6:0]  LV_DEF10    = 7'h2C
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sel_hi_pin,
   input  logic       sel_lo_pin,
   input  logic       wr_en,
   input  logic [3:0] wr_addr,
   input  logic [7:0] wr_data,
   input  logic [3:0] rd_addr,
   output logic [7:0] rd_data,
   output logic [3:0] bw_code,
   output logic [6:0] los_code,
   output logic       out_disable,
   output logic       los_range_hi,
   output logic       ofs_cancel_off,
   output logic       bus_lock,
   output logic [7:0] thresh_adj,
   output logic [3:0] preemph,
   output logic       preemph_bad,
   output logic [1:0] amp_level
);

   localparam int unsigned ADDR_W = 4;
   localparam int unsigned DATA_W = 8;
   localparam int unsigned NREG   = 12;

   logic [NREG-1:0][DATA_W-1:0] regs;
   logic [1:0]                  pair_s;
   logic                        lock;

   rsb_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({sel_hi_pin, sel_lo_pin}),
      .q_o   (pair_s)
   );

   rsb_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NREG(NREG)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .regs_o  (regs),
      .lock_o  (lock)
   );

   rsb_resolve #(
      .BW_W(4), .LV_W(7),
      .LV_DEF00(LV_DEF00), .LV_DEF01(LV_DEF01),
      .LV_DEF11(LV_DEF11), .LV_DEF10(LV_DEF10)
   ) u_res (
      .clk       (clk),
      .rst_n     (rst_n),
      .pair_i    (pair_s),
      .bw_regs_i (regs[ADR_BW0+3:ADR_BW0]),
      .lv_regs_i (regs[ADR_LOS0+3:ADR_LOS0]),
      .bw_o      (bw_code),
      .lv_o      (los_code)
   );

   // decoded control fields
   assign bus_lock       = lock;
   assign ofs_cancel_off = regs[ADR_CTRL][1];
   assign los_range_hi   = regs[ADR_CTRL][2];
   assign out_disable    = regs[ADR_CTRL][3];
   assign thresh_adj     = regs[ADR_THR];
   assign preemph        = regs[ADR_PE][3:0];
   assign preemph_bad    = !pe_code_ok(regs[ADR_PE][3:0]);

   amp_lvl_e amp_dec;
   always_comb begin
      case (regs[ADR_AMP][1:0])
         2'b00:   amp_dec = AMP_LOW;
         2'b11:   amp_dec = AMP_HIGH;
         default: amp_dec = AMP_MID;
      endcase
   end
   assign amp_level = amp_dec;

   always_comb begin
      if (rd_addr == 4'(ADR_BWSTAT))      rd_data = {4'b0, bw_code};
      else if (rd_addr == 4'(ADR_LVSTAT)) rd_data = {1'b0, los_code};
      else if (rd_addr < 4'(NREG))        rd_data = regs[rd_addr];
      else                                rd_data = '0;
   end

endmodule

// File: tb/sim_ratesel_ctrl_bank.sv
`timescale 1ns/1ps
module sim_ratesel_ctrl_bank;

   localparam logic [6:0] D00 = 7'h11, D01 = 7'h22, D11 = 7'h33, D10 = 7'h44;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sel_hi_pin = 1'b0, sel_lo_pin = 1'b0;
   logic       wr_en = 1'b0;
   logic [3:0] wr_addr = '0, rd_addr = '0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic [3:0] bw_code, preemph;
   logic [6:0] los_code;
   logic       out_disable, los_range_hi, ofs_cancel_off, bus_lock, preemph_bad;
   logic [7:0] thresh_adj;
   logic [1:0] amp_level;

   int unsigned n_chk = 0, n_bad = 0;
   logic [7:0]  m [12];
   logic        m_lock = 1'b0;

   always #4 clk = ~clk;

   ratesel_ctrl_bank #(.SYNC_STAGES(2), .LV_DEF00(D00), .LV_DEF01(D01),
                       .LV_DEF11(D11), .LV_DEF10(D10)) u0 (.*);

   function automatic logic [7:0] msk(input int a);
      if (a == 0 || a == 2) return 8'h0F;
      if (a == 3)           return 8'h03;
      if (a >= 4 && a < 8)  return 8'h8F;
      return 8'hFF;
   endfunction

   function automatic int slot(input logic [1:0] p);
      case (p) 2'b00: return 0; 2'b01: return 1; 2'b11: return 2; default: return 3; endcase
   endfunction

   function automatic logic [3:0] e_bw(input logic [1:0] p);
      logic [3:0] dft [4] = '{4'hF, 4'h5, 4'h2, 4'h0};
      int s = slot(p);
      return m[4+s][7] ? m[4+s][3:0] : dft[s];
   endfunction

   function automatic logic [6:0] e_lv(input logic [1:0] p);
      logic [6:0] dft [4] = '{D00, D01, D11, D10};
      int s = slot(p);
      return m[8+s][7] ? m[8+s][6:0] : dft[s];
   endfunction

   function automatic logic e_pe_bad(input logic [3:0] c);
      return !(c inside {4'd0, 4'd1, 4'd3, 4'd4, 4'd5, 4'd7, 4'd12, 4'd13, 4'd15});
   endfunction

   function automatic logic [1:0] e_amp(input logic [1:0] c);
      return (c == 2'b00) ? 2'd0 : (c == 2'b11) ? 2'd2 : 2'd1;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      if (!m_lock && a < 12) begin
         m[a] = d & msk(a);
         m_lock = m[0][0];
      end
   endtask

   task automatic rd_chk(input string req, input int a);
      logic [1:0] p = {sel_hi_pin, sel_lo_pin};
      logic [7:0] e;
      if (a < 12)       e = m[a];
      else if (a == 14) e = {4'b0, e_bw(p)};
      else if (a == 15) e = {1'b0, e_lv(p)};
      else              e = 8'h00;
      rd_addr = 4'(a);
      #1;
      chk(req, rd_data, e);
   endtask

   task automatic chk_outs(input string req);
      logic [1:0] p = {sel_hi_pin, sel_lo_pin};
      chk({req, " bw"},   bw_code,  e_bw(p));
      chk({req, " lv"},   los_code, e_lv(p));
      chk("R2 ctrl", {out_disable, los_range_hi, ofs_cancel_off, bus_lock}, m[0][3:0]);
      chk("R3 thr",  thresh_adj, m[1]);
      chk("R4 pe",   preemph, m[2][3:0]);
      chk("R5 bad",  preemph_bad, e_pe_bad(m[2][3:0]));
      chk("R4 amp",  amp_level, e_amp(m[3][1:0]));
   endtask

   task automatic pins(input logic [1:0] p);
      @(negedge clk);
      {sel_hi_pin, sel_lo_pin} = p;
      repeat (3) @(negedge clk);
   endtask

   task automatic summary;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      for (int i = 0; i < 12; i++) m[i] = '0;
      void'($urandom(32'd20240611));
      // R11: pins held at 00 through reset; synchroniser reads 10
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset bw", bw_code, 4'h0);
      chk("R1 reset lv", los_code, D10);
      chk("R1 reset ctrl", {out_disable, los_range_hi, ofs_cancel_off, bus_lock,
                            thresh_adj, preemph, preemph_bad, amp_level}, '0);
      @(negedge clk);
      chk("R11 sync reset value", bw_code, 4'h0);
      @(negedge clk);
      chk("R10 pin latency bw", bw_code, 4'hF);
      chk("R10 pin latency lv", los_code, D00);

      // R6/R7 defaults for every pair
      for (int p = 0; p < 4; p++) begin
         pins(2'(p));
         chk_outs("R6 R7 default");
      end

      // R10 write latency: program register 11 while pair 10 selected
      pins(2'b10);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 4'd11; wr_data = 8'hDA;
      @(negedge clk);
      wr_en = 1'b0;
      chk("R10 write edge lv", los_code, D10);
      m[11] = 8'hDA;
      @(negedge clk);
      chk("R10 write+1 lv", los_code, 7'h5A);

      // R5 / R4 directed sweeps
      for (int c = 0; c < 16; c++) begin
         wr(2, 8'(c) | 8'hF0);
         chk("R5 pe bad", preemph_bad, e_pe_bad(4'(c)));
         rd_chk("R5 pe stored", 2);
      end
      for (int c = 0; c < 4; c++) begin
         wr(3, 8'(c) | 8'hFC);
         chk("R4 amp", amp_level, e_amp(2'(c)));
         rd_chk("R4 amp unused", 3);
      end
      wr(1, 8'd128); rd_chk("R3 zero shift", 1);
      wr(14, 8'hFF); wr(15, 8'hFF); wr(12, 8'hFF);
      for (int a = 12; a < 16; a++) rd_chk("R8 status", a);

      // constrained random
      for (int it = 0; it < 300; it++) begin
         int a = int'($urandom_range(15, 0));
         logic [7:0] d = 8'($urandom);
         if (a == 0) d[0] = 1'b0;
         if (a >= 4 && a < 12 && ($urandom_range(3, 0) == 0)) d[7] = 1'b0;
         @(negedge clk);
         {sel_hi_pin, sel_lo_pin} = 2'($urandom);
         wr(a, d);
         repeat (3) @(negedge clk);
         chk_outs("R6 R7 random");
         rd_chk("R8 readback", a);
         rd_chk("R8 status bw", 14);
         rd_chk("R8 status lv", 15);
      end

      // R2 field positions
      wr(0, 8'hFE);
      chk("R2 ctrl", {out_disable, los_range_hi, ofs_cancel_off, bus_lock}, 4'b1110);
      rd_chk("R2 upper zero", 0);

      // R9 write lock
      wr(0, 8'h05);
      chk("R9 lock set", bus_lock, 1'b1);
      wr(1, 8'h3C); wr(7, 8'h81); wr(0, 8'h00); wr(11, 8'h80);
      repeat (2) @(negedge clk);
      chk("R9 lock sticky", bus_lock, 1'b1);
      for (int a = 0; a < 12; a++) rd_chk("R9 reads while locked", a);
      chk_outs("R9 outputs unchanged");

      summary();
   end

endmodule